// File: doc/BRIEF.md
# Nested Interrupt Priority Register with Entry Gate

This block holds the interrupt priority of a small processor core as a short stack of 2-bit levels packed into one byte. The level in force is always in the lowest two bits. Raising the priority pushes a new level in at the bottom and moves the older levels up by one slot. Restoring the priority rotates the byte right by one slot, so the level that was in force before comes back to the bottom. Software can also load the whole byte from memory, which is how the register is popped. The byte is always visible on an output, so software can also store it to memory, which is how the register is pushed.

The same block decides whether a pending interrupt may be taken at an instruction boundary. A request is taken only when its level is strictly above the level in force. It is also refused at the first boundary after any privileged instruction. This guarantees that the instruction after a priority change, a stack pointer load or a memory bit test runs before any interrupt. When a request is taken, its level is pushed onto the register at the same clock edge that raises the accept output. The core supplies the operation strobes, the boundary strobe and the request. Vectoring and the memory stack are handled elsewhere.

Top module: `prio_nest_gate`

## Requirements
- R1: A synchronous active-high reset sets the priority byte to 0xFF and clears the accept output, so no request is taken until software lowers the level.
- R2: A push strobe with a 2-bit immediate makes the byte, one cycle later, equal to the old byte shifted left by two bits with the immediate in bits [1:0].
- R3: A restore strobe makes the byte, one cycle later, equal to the old byte rotated right by two bits (old bits [1:0] go to bits [7:6]).
- R4: A load strobe makes the byte equal to the load input one cycle later. The byte output always shows the current register value, which software uses to store the register to memory.
- R5: When strobes coincide, load wins over push, and push wins over restore. An accepted interrupt changes the byte only when no strobe is present.
- R6: A request is taken only in a cycle with the boundary strobe, the request flag high, its level strictly greater than bits [1:0] of the byte, and no block in force. The accept output is high for exactly the cycle after that boundary.
- R7: On acceptance, the byte becomes the old byte shifted left by two bits with the request level in bits [1:0], at the same edge that raises accept.
- R8: A push, restore or load strobe, or the privileged-instruction strobe, blocks acceptance at a boundary in the same cycle. Otherwise it blocks acceptance at the first later boundary. Only that one boundary is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Push the immediate level |
| push_lvl | input | 2 | Immediate level for push |
| rest_en | input | 1 | Restore the previous level (rotate right) |
| load_en | input | 1 | Load the whole byte (pop from memory) |
| load_val | input | 8 | Byte to load |
| priv_en | input | 1 | Another privileged instruction has executed |
| bound_en | input | 1 | Instruction boundary |
| irq_req | input | 1 | Interrupt pending |
| irq_lvl | input | 2 | Level of the pending interrupt |
| ip_byte | output | 8 | Current priority byte |
| irq_take | output | 1 | Interrupt accepted at the previous boundary |

## Verification
Every result takes one clock: a strobe or an accepted request appears on the priority byte after the next rising edge, and accept rises at that same edge. The bench applies inputs on the falling edge and updates its own behavioural model at the rising edge. It then compares both outputs on the next falling edge, on every cycle. A block takes effect no later than the first boundary after its strobe, so the bench places boundaries both in the strobe cycle and several idle cycles later. It then checks that the following boundary accepts again.

// File: rtl/ipstk_pkg.sv
package ipstk_pkg;
  typedef enum logic [1:0] {
    IPOP_HOLD   = 2'd0,
    IPOP_LOAD   = 2'd1,
    IPOP_PUSH   = 2'd2,
    IPOP_ROTATE = 2'd3
  } ipop_e;
endpackage

// File: rtl/ipstk_entry_guard.sv
module ipstk_entry_guard (
  input  logic clk,
  input  logic rst,
  input  logic priv_now,
  input  logic bound_en,
  output logic blocked
);
  logic armed_q;

  // block this boundary if a privileged op ends here or armed earlier
  assign blocked = armed_q | priv_now;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= (armed_q | priv_now) & ~bound_en;
  end
endmodule

// File: rtl/ipstk_arbiter.sv
module ipstk_arbiter #(
  parameter int LVL_W = 2
) (
  input  logic             bound_en,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic             blocked,
  output logic             take
);
  always_comb begin
    take = bound_en & irq_req & ~blocked & (irq_lvl > cur_lvl);
  end
endmodule

// File: rtl/ipstk_level_reg.sv
module ipstk_level_reg
  import ipstk_pkg::*;
#(
  parameter int LVL_W = 2,
  parameter int DEPTH = 4,
  localparam int IP_W = LVL_W * DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  ipop_e            op,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic [IP_W-1:0]  load_val,
  input  logic             take,
  input  logic [LVL_W-1:0] take_lvl,
  output logic [IP_W-1:0]  ip_q,
  output logic             take_q
);
  logic [IP_W-1:0] ip_n;

  always_comb begin
    ip_n = ip_q;
    unique case (op)
      IPOP_LOAD:   ip_n = load_val;
      IPOP_PUSH:   ip_n = {ip_q[IP_W-LVL_W-1:0], push_lvl};
      IPOP_ROTATE: ip_n = {ip_q[LVL_W-1:0], ip_q[IP_W-1:LVL_W]};
      default: begin
        if (take) ip_n = {ip_q[IP_W-LVL_W-1:0], take_lvl};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q   <= '1;
      take_q <= 1'b0;
    end else begin
      ip_q   <= ip_n;
      take_q <= take;
    end
  end
endmodule

// File: rtl/prio_nest_gate.sv
module prio_nest_gate
  import ipstk_pkg::*;
#(
  parameter int LVL_W = 2,
  parameter int DEPTH = 4,
  localparam int IP_W = LVL_W * DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             rest_en,
  input  logic             load_en,
  input  logic [IP_W-1:0]  load_val,
  input  logic             priv_en,
  input  logic             bound_en,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_lvl,
  output logic [IP_W-1:0]  ip_byte,
  output logic             irq_take
);
  ipop_e op;
  logic  priv_now;
  logic  blocked;
  logic  take;

  always_comb begin
    if (load_en)      op = IPOP_LOAD;
    else if (push_en) op = IPOP_PUSH;
    else if (rest_en) op = IPOP_ROTATE;
    else              op = IPOP_HOLD;
  end

  assign priv_now = priv_en | (op != IPOP_HOLD);

  ipstk_entry_guard u_guard (
    .clk(clk), .rst(rst), .priv_now(priv_now),
    .bound_en(bound_en), .blocked(blocked)
  );

  ipstk_arbiter #(.LVL_W(LVL_W)) u_arb (
    .bound_en(bound_en), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .cur_lvl(ip_byte[LVL_W-1:0]), .blocked(blocked), .take(take)
  );

  ipstk_level_reg #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_reg (
    .clk(clk), .rst(rst), .op(op), .push_lvl(push_lvl),
    .load_val(load_val), .take(take), .take_lvl(irq_lvl),
    .ip_q(ip_byte), .take_q(irq_take)
  );
endmodule

// File: rtl/prio_nest_gate_chk.sv
module prio_nest_gate_chk #(
  parameter int LVL_W = 2,
  parameter int DEPTH = 4,
  localparam int IP_W = LVL_W * DEPTH
) (
  input logic             clk,
  input logic             rst,
  input logic             push_en,
  input logic [LVL_W-1:0] push_lvl,
  input logic             rest_en,
  input logic             load_en,
  input logic [IP_W-1:0]  load_val,
  input logic             priv_en,
  input logic             bound_en,
  input logic             irq_req,
  input logic [LVL_W-1:0] irq_lvl,
  input logic [IP_W-1:0]  ip_byte,
  input logic             irq_take
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> $past(bound_en && irq_req)); // R6
  AST_TAKE_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> ($past(irq_lvl) > $past(ip_byte[LVL_W-1:0]))); // R6
  AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (ip_byte == {$past(ip_byte[IP_W-LVL_W-1:0]), $past(irq_lvl)})); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_en)) |-> (ip_byte == $past(load_val))); // R5
  AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rest_en) && !$past(load_en) && !$past(push_en))
      |-> (ip_byte == {$past(ip_byte[LVL_W-1:0]), $past(ip_byte[IP_W-1:LVL_W])})); // R3
  AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (push_en || rest_en || load_en || priv_en) |=> !irq_take); // R8
endmodule

bind prio_nest_gate prio_nest_gate_chk #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/prio_nest_gate_bench.sv
module prio_nest_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_en = 0, rest_en = 0, load_en = 0, priv_en = 0;
  logic       bound_en = 0, irq_req = 0;
  logic [1:0] push_lvl = 0, irq_lvl = 0;
  logic [7:0] load_val = 0;
  logic [7:0] ip_byte;
  logic       irq_take;

  int n_run = 0, n_fail = 0;
  int m_ip = 255, m_pend = 0;
  bit m_acc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prio_nest_gate u_prio_nest_gate (
    .clk(clk), .rst(rst), .push_en(push_en), .push_lvl(push_lvl),
    .rest_en(rest_en), .load_en(load_en), .load_val(load_val),
    .priv_en(priv_en), .bound_en(bound_en), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .ip_byte(ip_byte), .irq_take(irq_take)
  );

  task automatic cyc(input string tag, input bit r, input bit ld, input int lv,
                     input bit ps, input int pl, input bit rs, input bit pv,
                     input bit bd, input bit rq, input int ql);
    bit priv, acc;
    rst = r; load_en = ld; load_val = lv[7:0]; push_en = ps; push_lvl = pl[1:0];
    rest_en = rs; priv_en = pv; bound_en = bd; irq_req = rq; irq_lvl = ql[1:0];
    @(posedge clk);
    if (r) begin
      m_ip = 255; m_acc = 0; m_pend = 0;
    end else begin
      priv = ld || ps || rs || pv;
      acc  = bd && rq && !(m_pend != 0 || priv) && (ql > (m_ip % 4));
      if (ld)       m_ip = lv;
      else if (ps)  m_ip = ((m_ip * 4) % 256) + pl;
      else if (rs)  m_ip = (m_ip / 4) + ((m_ip % 4) * 64);
      else if (acc) m_ip = ((m_ip * 4) % 256) + ql;
      m_acc  = acc;
      m_pend = ((m_pend != 0 || priv) && !bd) ? 1 : 0;
    end
    @(negedge clk);
    n_run++;
    if (ip_byte !== m_ip[7:0] || irq_take !== m_acc) begin
      n_fail++;
      $display("FAIL %s: ip=%02h take=%0b expected ip=%02h take=%0b",
               tag, ip_byte, irq_take, m_ip[7:0], m_acc);
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // level 3 request against reset level 3: refused
    cyc("R1 masked after reset", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    // load 0x00 with a boundary in the same cycle: blocked
    cyc("R4 load", 0, 1, 8'h00, 0, 0, 0, 0, 1, 1, 1);
    cyc("R6 accept lvl1", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    cyc("R7 push on accept", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6 equal level refused", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    cyc("R6 no boundary", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    cyc("R6 no request", 0, 0, 0, 0, 0, 0, 0, 1, 0, 2);
    cyc("R7 accept lvl2", 0, 0, 0, 0, 0, 0, 0, 1, 1, 2);
    // push without boundary, then first later boundary blocked
    cyc("R2 push", 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
    idle("R8 idle", 3);
    cyc("R8 delayed block", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    cyc("R3 restore", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R8 block after restore", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    cyc("R8 only one boundary", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    // privileged strobe without op
    cyc("R4 load low", 0, 1, 8'h40, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 clear pend", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R8 priv strobe", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R8 block after priv", 0, 0, 0, 0, 0, 0, 0, 1, 1, 2);
    cyc("R6 accept after block", 0, 0, 0, 0, 0, 0, 0, 1, 1, 2);
    cyc("R8 priv with boundary", 0, 0, 0, 0, 0, 0, 1, 1, 1, 3);
    cyc("R6 next boundary free", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    // coincident strobes
    cyc("R5 load beats push", 0, 1, 8'h5A, 1, 1, 1, 0, 0, 0, 0);
    cyc("R5 push beats restore", 0, 0, 0, 1, 2, 1, 0, 0, 0, 0);
    cyc("R3 rotate wrap", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R3 rotate again", 0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    cyc("R2 push lvl0", 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R6 accept from 0", 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    // reset in mid run
    cyc("R1 reset again", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R1 blocked at ff", 0, 0, 0, 0, 0, 0, 0, 1, 1, 3);
    idle("R4 hold", 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule